// File: doc/BRIEF.md
# Display RAM address and data controller

This block owns the single 7-bit address counter that a character display controller shares between two internal memories. One is a 64-word character-pattern RAM with 5-bit words. The other is a 128-word display-data RAM with 8-bit words. A host-bus front end hands it one already-decoded operation per cycle: load a pattern-RAM address, load a display-RAM address, write data, read data, read status, or a miscellaneous display command (clear, home, shift) that is handled elsewhere. The block keeps the memory selection, moves the counter after data accesses, and drives a busy flag that holds off further commands.

Reads are served from a prefetched data register. A read returns the word fetched earlier and then refetches at the stepped address. Only the two address loads and a read refill that register. A write can therefore leave the register holding a value that is no longer in RAM. A status read can be issued at any time. It returns the busy flag above the counter value.

Top module: `disp_ram_ctrl`

## Requirements
- R1: After reset the counter is 0, busy is low, the output word is 0x00, the display RAM is selected and the prefetch register holds 0x00.
- R2: A display-address load (op code 2) copies operand bits 6:0 into all seven counter bits and selects the display RAM.
- R3: A pattern-address load (op code 1) copies operand bits 5:0 into counter bits 5:0, leaves counter bit 6 as it was, and selects the pattern RAM.
- R4: A write (op code 3) stores the operand at the counter address in the RAM selected by the latest address load. The pattern RAM keeps only operand bits 4:0 and reads back with bits 7:5 as zero.
- R5: After every accepted write or read, the counter moves by one, upward when entry_inc is 1 and downward when it is 0. It wraps modulo 128.
- R6: A read (op code 4) places the prefetch register on dout one cycle after acceptance. The register is then refilled from the selected RAM at the stepped address.
- R7: Either address load refills the prefetch register from the selected RAM at the new address.
- R8: A write or a miscellaneous command (op codes 6 and 7) leaves the prefetch register unchanged. Op codes 6 and 7 also leave the counter unchanged.
- R9: A status read (op code 5) is taken even while busy. It does not raise busy. One cycle later dout holds busy in bit 7 and the counter in bits 6:0, both as they were in the cycle the request was presented.
- R10: Every accepted operation other than status and no-op (op code 0) holds busy high for exactly BUSY_CYC cycles. Non-status requests that arrive while busy is high have no effect.
- R11: A pattern-RAM write at counter 63 with an upward step carries into counter bit 6, giving 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 3 | Operation code: 0 none, 1 pattern address, 2 display address, 3 write, 4 read, 5 status, 6/7 miscellaneous |
| op_arg | input | 8 | Address operand or write data |
| entry_inc | input | 1 | Step direction for data accesses: 1 up, 0 down |
| busy | output | 1 | Internal operation in progress |
| dout | output | 8 | Read data or status word |

## Verification
An accepted operation changes the counter, the selection and dout at the clock edge where it is accepted. The prefetch refill lands one edge later. Busy falls BUSY_CYC edges after acceptance. The bench drives a request on a falling edge and samples dout on the next falling edge. Before it issues the next command, it waits BUSY_CYC further falling edges. Refetched values are therefore only ever observed through a later read, by which time the refill has finished. The busy window is measured by counting falling edges with busy high. A status request placed inside that window checks that status is taken and that competing commands are dropped.

// File: rtl/drc_pkg.sv
package drc_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_SET_PG = 3'd1,
        OP_SET_DS = 3'd2,
        OP_WRITE  = 3'd3,
        OP_READ   = 3'd4,
        OP_STATUS = 3'd5,
        OP_MISC_A = 3'd6,
        OP_MISC_B = 3'd7
    } drc_op_e;

    function automatic logic op_is_command(input drc_op_e op);
        return (op != OP_NONE) && (op != OP_STATUS);
    endfunction

endpackage

// File: rtl/drc_addr_ctr.sv
module drc_addr_ctr #(
    parameter int AC_W = 7,
    parameter int PG_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_full,
    input  logic            ld_low,
    input  logic            step,
    input  logic            step_up,
    input  logic [AC_W-1:0] ld_val,
    output logic [AC_W-1:0] ac
);
    localparam logic [AC_W-1:0] ONE = AC_W'(1);

    logic [AC_W-1:0] ac_d, ac_q;

    always_comb begin
        ac_d = ac_q;
        if (ld_full) begin
            ac_d = ld_val;
        end else if (ld_low) begin
            ac_d = {ac_q[AC_W-1:PG_W], ld_val[PG_W-1:0]};
        end else if (step) begin
            ac_d = step_up ? (ac_q + ONE) : (ac_q - ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ac_q <= '0;
        else        ac_q <= ac_d;
    end

    assign ac = ac_q;
endmodule

// File: rtl/drc_ram_bank.sv
module drc_ram_bank #(
    parameter int AC_W  = 7,
    parameter int PG_W  = 6,
    parameter int DW    = 8,
    parameter int PG_DW = 5
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic            sel_pg,
    input  logic [AC_W-1:0] addr,
    input  logic [DW-1:0]   wr_data,
    output logic [DW-1:0]   rd_data
);
    localparam int PG_DEPTH = 1 << PG_W;
    localparam int DS_DEPTH = 1 << AC_W;

    logic [PG_DW-1:0] pg_mem [PG_DEPTH];
    logic [DW-1:0]    ds_mem [DS_DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && sel_pg)  pg_mem[addr[PG_W-1:0]] <= wr_data[PG_DW-1:0];
        if (wr_en && !sel_pg) ds_mem[addr]           <= wr_data;
    end

    always_comb begin
        rd_data = '0;
        if (sel_pg) rd_data[PG_DW-1:0] = pg_mem[addr[PG_W-1:0]];
        else        rd_data            = ds_mem[addr];
    end
endmodule

// File: rtl/drc_busy_tmr.sv
module drc_busy_tmr #(
    parameter int BUSY_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(BUSY_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          busy;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.cnt  = LOAD;
            s_d.busy = 1'b1;
        end else if (s_q.cnt != '0) begin
            s_d.cnt  = s_q.cnt - CW'(1);
            s_d.busy = (s_q.cnt != CW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
endmodule

// File: rtl/disp_ram_ctrl.sv
module disp_ram_ctrl #(
    parameter int AC_W     = 7,
    parameter int PG_W     = 6,
    parameter int DW       = 8,
    parameter int PG_DW    = 5,
    parameter int BUSY_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [2:0]    op_kind,
    input  logic [DW-1:0] op_arg,
    input  logic          entry_inc,
    output logic          busy,
    output logic [DW-1:0] dout
);
    import drc_pkg::*;

    typedef struct packed {
        logic          sel_pg;
        logic          refill;
        logic [DW-1:0] pre;
        logic [DW-1:0] out;
    } ctl_t;

    ctl_t c_d, c_q;

    drc_op_e         op;
    logic            accept;
    logic            is_stat;
    logic [AC_W-1:0] ac;
    logic [DW-1:0]   ram_rd;
    logic [DW-1:0]   stat_word;

    assign op      = drc_op_e'(op_kind);
    assign accept  = op_valid && op_is_command(op) && !busy;
    assign is_stat = op_valid && (op == OP_STATUS);

    drc_addr_ctr #(.AC_W(AC_W), .PG_W(PG_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_full (accept && (op == OP_SET_DS)),
        .ld_low  (accept && (op == OP_SET_PG)),
        .step    (accept && ((op == OP_WRITE) || (op == OP_READ))),
        .step_up (entry_inc),
        .ld_val  (op_arg[AC_W-1:0]),
        .ac      (ac)
    );

    drc_ram_bank #(.AC_W(AC_W), .PG_W(PG_W), .DW(DW), .PG_DW(PG_DW)) u_ram (
        .clk     (clk),
        .wr_en   (accept && (op == OP_WRITE)),
        .sel_pg  (c_q.sel_pg),
        .addr    (ac),
        .wr_data (op_arg),
        .rd_data (ram_rd)
    );

    drc_busy_tmr #(.BUSY_CYC(BUSY_CYC)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .busy  (busy)
    );

    always_comb begin
        stat_word          = '0;
        stat_word[AC_W]    = busy;
        stat_word[AC_W-1:0] = ac;
    end

    always_comb begin
        c_d        = c_q;
        c_d.refill = 1'b0;
        if (c_q.refill) begin
            c_d.pre = ram_rd;
        end
        if (accept) begin
            unique case (op)
                OP_SET_PG: begin
                    c_d.sel_pg = 1'b1;
                    c_d.refill = 1'b1;
                end
                OP_SET_DS: begin
                    c_d.sel_pg = 1'b0;
                    c_d.refill = 1'b1;
                end
                OP_READ: begin
                    c_d.out    = c_q.pre;
                    c_d.refill = 1'b1;
                end
                default: ;
            endcase
        end
        if (is_stat) begin
            c_d.out = stat_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign dout = c_q.out;
endmodule

// File: rtl/drc_chk.sv
module drc_chk #(
    parameter int AC_W = 7,
    parameter int DW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [2:0]      op_kind,
    input logic [DW-1:0]   op_arg,
    input logic            entry_inc,
    input logic            busy,
    input logic [DW-1:0]   dout,
    input logic [AC_W-1:0] ac,
    input logic [DW-1:0]   pre
);
    logic take;
    assign take = op_valid && !busy && (op_kind != 3'd0) && (op_kind != 3'd5);

    // R2
    ds_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && op_kind == 3'd2 |=> ac == $past(op_arg[AC_W-1:0]));

    // R3
    pg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && op_kind == 3'd1 |=> ac[AC_W-1] == $past(ac[AC_W-1])
                                  && ac[AC_W-2:0] == $past(op_arg[AC_W-2:0]));

    // R5
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && op_kind == 3'd3 && entry_inc |=> ac == AC_W'($past(ac) + 1));

    // R6
    read_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && op_kind == 3'd4 |=> dout == $past(pre));

    // R8
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && (op_kind == 3'd3 || op_kind[2:1] == 2'b11) |=> $stable(pre));

    // R9
    status_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_kind == 3'd5 |=> dout == {$past(busy), $past(ac)});

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && op_valid && op_kind != 3'd5 |=> $stable(ac));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> busy);
endmodule

bind disp_ram_ctrl drc_chk #(.AC_W(AC_W), .DW(DW)) u_drc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_kind   (op_kind),
    .op_arg    (op_arg),
    .entry_inc (entry_inc),
    .busy      (busy),
    .dout      (dout),
    .ac        (ac),
    .pre       (c_q.pre)
);

// File: tb/test_disp_ram_ctrl.sv
module test_disp_ram_ctrl;
    localparam int BUSY_CYC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [2:0] op_kind = 3'd0;
    logic [7:0] op_arg = 8'h00;
    logic       entry_inc = 1'b1;
    logic       busy;
    logic [7:0] dout;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;
    logic [7:0] got;

    always #10 clk = ~clk;

    disp_ram_ctrl #(.BUSY_CYC(BUSY_CYC)) i_disp_ram_ctrl (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_arg(op_arg), .entry_inc(entry_inc), .busy(busy), .dout(dout)
    );

    typedef struct packed {
        logic [2:0] kind;
        logic [7:0] arg;
        logic       inc;
        logic       chk;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{3'd2, 8'h10, 1'b1, 1'b0, 8'h00, 4'd2},  // R2 load display address
        '{3'd3, 8'hA5, 1'b1, 1'b0, 8'h00, 4'd4},  // R4 write
        '{3'd3, 8'h3C, 1'b1, 1'b0, 8'h00, 4'd4},
        '{3'd5, 8'h00, 1'b1, 1'b1, 8'h12, 4'd5},  // R5 two upward steps
        '{3'd2, 8'h10, 1'b1, 1'b0, 8'h00, 4'd7},  // R7 refill on load
        '{3'd4, 8'h00, 1'b1, 1'b1, 8'hA5, 4'd6},  // R6 prefetched word
        '{3'd4, 8'h00, 1'b1, 1'b1, 8'h3C, 4'd6},  // R6 refilled at next address
        '{3'd5, 8'h00, 1'b1, 1'b1, 8'h12, 4'd5},
        '{3'd1, 8'h3F, 1'b1, 1'b0, 8'h00, 4'd3},  // R3
        '{3'd5, 8'h00, 1'b1, 1'b1, 8'h3F, 4'd3},
        '{3'd3, 8'hFF, 1'b1, 1'b0, 8'h00, 4'd11}, // R11 carry into bit 6
        '{3'd5, 8'h00, 1'b1, 1'b1, 8'h40, 4'd11},
        '{3'd1, 8'h05, 1'b1, 1'b0, 8'h00, 4'd3},  // R3 bit 6 kept
        '{3'd5, 8'h00, 1'b1, 1'b1, 8'h45, 4'd3},
        '{3'd1, 8'h3F, 1'b1, 1'b0, 8'h00, 4'd7},
        '{3'd4, 8'h00, 1'b1, 1'b1, 8'h1F, 4'd4},  // R4 pattern word masked
        '{3'd5, 8'h00, 1'b1, 1'b1, 8'h00, 4'd5},  // R5 wrap 127 to 0
        '{3'd2, 8'h11, 1'b1, 1'b0, 8'h00, 4'd2},
        '{3'd3, 8'h77, 1'b0, 1'b0, 8'h00, 4'd8},  // R8 write keeps prefetch
        '{3'd6, 8'h00, 1'b1, 1'b0, 8'h00, 4'd8},  // R8 misc command
        '{3'd4, 8'h00, 1'b0, 1'b1, 8'h3C, 4'd8},  // R8 stale word returned
        '{3'd5, 8'h00, 1'b1, 1'b1, 8'h0F, 4'd5},  // R5 downward steps
        '{3'd2, 8'h11, 1'b1, 1'b0, 8'h00, 4'd2},
        '{3'd4, 8'h00, 1'b1, 1'b1, 8'h77, 4'd4},
        '{3'd2, 8'h00, 1'b1, 1'b0, 8'h00, 4'd2},
        '{3'd3, 8'h12, 1'b0, 1'b0, 8'h00, 4'd5},
        '{3'd7, 8'h00, 1'b1, 1'b0, 8'h00, 4'd8},
        '{3'd5, 8'h00, 1'b1, 1'b1, 8'h7F, 4'd5}   // R5 wrap 0 to 127, R8 counter kept
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] k, input logic [7:0] a, input logic inc);
        op_valid  = 1'b1;
        op_kind   = k;
        op_arg    = a;
        entry_inc = inc;
        @(negedge clk);
        op_valid  = 1'b0;
        op_kind   = 3'd0;
        got       = dout;
    endtask

    task automatic do_op(input logic [2:0] k, input logic [7:0] a, input logic inc);
        drive(k, a, inc);
        repeat (BUSY_CYC) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", {7'd0, busy}, 8'h00);
        check("R1 dout", dout, 8'h00);
        do_op(3'd5, 8'h00, 1'b1);
        check("R1 status", got, 8'h00);
        do_op(3'd4, 8'h00, 1'b1);
        check("R1 prefetch", got, 8'h00);

        for (int i = 0; i < NV; i++) begin
            do_op(VECS[i].kind, VECS[i].arg, VECS[i].inc);
            if (VECS[i].chk)
                check($sformatf("R%0d vec%0d", VECS[i].req, i), got, VECS[i].exp);
        end

        // R10 and R9: status inside the busy window, competing load dropped
        drive(3'd2, 8'h20, 1'b1);
        check("R10 busy raised", {7'd0, busy}, 8'h01);
        drive(3'd5, 8'h00, 1'b1);
        check("R9 status while busy", got, 8'hA0);
        drive(3'd2, 8'h55, 1'b1);
        repeat (BUSY_CYC) @(negedge clk);
        do_op(3'd5, 8'h00, 1'b1);
        check("R10 ignored load", got, 8'h20);

        // R10 busy length
        begin
            int n = 0;
            drive(3'd6, 8'h00, 1'b1);
            while (busy && n < 100) begin
                n++;
                @(negedge clk);
            end
            check("R10 busy cycles", 8'(n), 8'(BUSY_CYC));
        end
        // R9 status does not raise busy
        drive(3'd5, 8'h00, 1'b1);
        check("R9 no busy", {7'd0, busy}, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule